// File: doc/BRIEF.md
# Banked Parallel Flash Command Sequencer

This block is a bus master that drives erase and program command sequences into a parallel flash device reached through a banked memory window. The flash answers to a 16 KB window at $8000-$BFFF. A bank register at $C000 selects which 16 KB page of the device that window shows. Every command cycle the flash expects is therefore issued as two bus writes. The first write loads the bank register. The second writes the command or data byte at an address inside the window.

A host pulses `start` with an operation, a target bank, a target address, a data byte and a poll budget. The engine then issues the unlock cycles followed by the final command cycle. After that it reads the target location again and again until two reads in a row return the value the operation should leave there. It ends with a one-cycle `done` pulse, or with a one-cycle `timeout` pulse once the poll budget is used up. A request whose address cannot be valid for its operation is refused at once with an `err` pulse, and no bus traffic follows.

Top module: `flash_cmd_seq`

## Requirements
- R1: While reset is held, and after it until the first start, `busy`, `done`, `timeout`, `err`, `bus_wr` and `bus_rd` are all low.
- R2: Every command cycle is two writes. The first writes to $C000 the bank value, zero-extended to 8 bits, with the bank number in bits 4:0. The second writes the cycle's data byte to the cycle's address.
- R3: An erase (`op_erase`=1) issues six command cycles as (bank, address, byte), in this order: (1,$9555,$AA), (0,$AAAA,$55), (1,$9555,$80), (1,$9555,$AA), (0,$AAAA,$55), (target bank, target address, $30). That is 12 writes.
- R4: A byte program (`op_erase`=0) issues four command cycles, in this order: (1,$9555,$AA), (0,$AAAA,$55), (1,$9555,$A0), (target bank, target address, data byte). That is 8 writes.
- R5: A request is rejected if its target address lies outside $8000-$BFFF (address bits 15:14 not equal to 2'b10), or if it is an erase whose address bits 11:0 are not zero. A rejected request gives an `err` pulse in the cycle after the start edge. It issues no write and no read.
- R6: After the last command cycle, the engine reads the target address until two consecutive reads both return the expected value. For an erase this is $FF; for a program it is the data byte. The engine then pulses `done`, and the number of reads equals the index of the second matching read plus one.
- R7: Matching reads that are not consecutive do not complete the operation.
- R8: If `poll_limit` reads (`poll_limit` at least 1) pass without completion, `timeout` pulses after the last of them and the engine goes back to idle. A completion on the final allowed read counts as `done`.
- R9: `done`, `timeout` and `err` are single-cycle pulses, each raised once per request. `busy` is high from the cycle after an accepted start until the cycle in which `done` or `timeout` is high, and low in that cycle.
- R10: A `start` seen while `busy` is high is ignored: it issues no bus access and changes no target.
- R11: A strobe (`bus_wr` or `bus_rd`) stays high, with address and write data stable, until `bus_ack` is seen. Each ack completes one access, and `bus_wr` and `bus_rd` are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse, sampled only when idle |
| op_erase | input | 1 | 1 = sector erase, 0 = byte program |
| bank_i | input | BANK_W | Target bank number |
| addr_i | input | 16 | Target address inside the window |
| data_i | input | 8 | Byte to program |
| poll_limit | input | POLL_W | Maximum number of completion reads |
| bus_addr | output | 16 | Bus address |
| bus_wdata | output | 8 | Bus write data |
| bus_wr | output | 1 | Write strobe, held until ack |
| bus_rd | output | 1 | Read strobe, held until ack |
| bus_ack | input | 1 | Access complete, one cycle |
| bus_rdata | input | 8 | Read data, valid with ack |
| busy | output | 1 | Request in progress |
| done | output | 1 | Completion pulse |
| timeout | output | 1 | Poll budget exhausted pulse |
| err | output | 1 | Request rejected pulse |

## Verification
A rejected request shows `err` one cycle after the start edge, with no strobe in between. Every other access lasts until the ack the bus stub returns two cycles after the strobe rises. `done` and `timeout` go high on the same edge that accepts the ack of the deciding read. The bench drives inputs and samples outputs only on falling edges. It waits for whichever pulse is due, then compares the logged write sequence, the read count and the read addresses against the values the requirements give. Pulse counters kept over a few trailing cycles confirm that each pulse lasts exactly one cycle.

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq #(
  parameter int BANK_W = 5,
  parameter int POLL_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              op_erase,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [15:0]       addr_i,
  input  logic [7:0]        data_i,
  input  logic [POLL_W-1:0] poll_limit,
  output logic [15:0]       bus_addr,
  output logic [7:0]        bus_wdata,
  output logic              bus_wr,
  output logic              bus_rd,
  input  logic              bus_ack,
  input  logic [7:0]        bus_rdata,
  output logic              busy,
  output logic              done,
  output logic              timeout,
  output logic              err
);

  localparam logic [15:0] BANK_REG = 16'hC000;
  localparam logic [15:0] UNLK_A   = 16'h9555;
  localparam logic [15:0] UNLK_B   = 16'hAAAA;

  typedef enum logic [1:0] {S_IDLE, S_BANK, S_DATA, S_POLL} st_t;

  st_t               st;
  logic [2:0]        step;
  logic              is_erase;
  logic [BANK_W-1:0] tbank;
  logic [15:0]       taddr;
  logic [7:0]        tdata;
  logic [POLL_W-1:0] limit;
  logic [POLL_W-1:0] pcount;
  logic              prev_hit;
  logic              done_q, to_q, err_q;

  logic [7:0]  sbank;
  logic [15:0] saddr;
  logic [7:0]  sdata;
  logic [2:0]  last_step;
  logic        hit, req_bad;

  assign last_step = is_erase ? 3'd5 : 3'd3;
  assign hit       = bus_rdata == (is_erase ? 8'hFF : tdata);
  assign req_bad   = (addr_i[15:14] != 2'b10) || (op_erase && addr_i[11:0] != 12'h000);

  always_comb begin
    sbank = 8'h01;
    saddr = UNLK_A;
    sdata = 8'hAA;
    case (step)
      3'd0: ;
      3'd1: begin sbank = 8'h00; saddr = UNLK_B; sdata = 8'h55; end
      3'd2: sdata = is_erase ? 8'h80 : 8'hA0;
      3'd3: if (!is_erase) begin sbank = 8'(tbank); saddr = taddr; sdata = tdata; end
      3'd4: begin sbank = 8'h00; saddr = UNLK_B; sdata = 8'h55; end
      default: begin sbank = 8'(tbank); saddr = taddr; sdata = 8'h30; end
    endcase
  end

  assign bus_wr    = (st == S_BANK) || (st == S_DATA);
  assign bus_rd    = st == S_POLL;
  assign bus_addr  = (st == S_BANK) ? BANK_REG : (st == S_POLL) ? taddr : saddr;
  assign bus_wdata = (st == S_BANK) ? sbank : (st == S_DATA) ? sdata : 8'h00;
  assign busy      = st != S_IDLE;
  assign done      = done_q;
  assign timeout   = to_q;
  assign err       = err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      step     <= '0;
      is_erase <= 1'b0;
      tbank    <= '0;
      taddr    <= '0;
      tdata    <= '0;
      limit    <= '0;
      pcount   <= '0;
      prev_hit <= 1'b0;
      done_q   <= 1'b0;
      to_q     <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      to_q   <= 1'b0;
      err_q  <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          if (req_bad) err_q <= 1'b1;
          else begin
            is_erase <= op_erase;
            tbank    <= bank_i;
            taddr    <= addr_i;
            tdata    <= data_i;
            limit    <= poll_limit;
            step     <= '0;
            st       <= S_BANK;
          end
        end
        S_BANK: if (bus_ack) st <= S_DATA;
        S_DATA: if (bus_ack) begin
          if (step == last_step) begin
            st       <= S_POLL;
            pcount   <= '0;
            prev_hit <= 1'b0;
          end else begin
            step <= step + 3'd1;
            st   <= S_BANK;
          end
        end
        S_POLL: if (bus_ack) begin
          if (hit && prev_hit) begin
            done_q <= 1'b1;
            st     <= S_IDLE;
          end else if (pcount == limit - 1'b1) begin
            to_q <= 1'b1;
            st   <= S_IDLE;
          end else begin
            pcount   <= pcount + 1'b1;
            prev_hit <= hit;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R11
  wr_rd_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_rd));

  // R11
  strobe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr || bus_rd) && !bus_ack |=>
      $stable(bus_addr) && $stable(bus_wdata) && $stable(bus_wr) && $stable(bus_rd));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  end_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done || timeout) |-> !busy);

  // R8
  timeout_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> $past(bus_rd && bus_ack));

  // R5
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !bus_wr && !bus_rd && !busy);

  // R10
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !bus_ack |=> busy);

endmodule

// File: tb/flash_cmd_seq_tb.sv
`timescale 1ns/1ps
module flash_cmd_seq_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, op_erase = 1'b0;
  logic [4:0] bank_i = '0;
  logic [15:0] addr_i = '0;
  logic [7:0] data_i = '0;
  logic [15:0] poll_limit = '0;
  logic [15:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata;
  logic bus_wr, bus_rd, bus_ack, busy, done, timeout, err;

  always #2 clk = ~clk;

  flash_cmd_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_erase(op_erase), .bank_i(bank_i),
    .addr_i(addr_i), .data_i(data_i), .poll_limit(poll_limit), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_ack(bus_ack),
    .bus_rdata(bus_rdata), .busy(busy), .done(done), .timeout(timeout), .err(err));

  int errors = 0, checks = 0, cyc = 0;
  logic [15:0] wl_addr [256];
  logic [7:0]  wl_data [256];
  int wcnt = 0, rcnt = 0, rd_badaddr = 0;
  int ndone = 0, nto = 0, nerr = 0;
  int cfg_nbad = 0;
  logic cfg_alt = 1'b0;
  logic [7:0] cfg_exp = 8'hFF;
  logic [15:0] cfg_addr = '0;
  int rbase = 0;

  function automatic logic rd_match(int i, int nbad, logic alt);
    return (i >= nbad) || (alt && i == 0);
  endfunction

  initial bus_ack = 1'b0;
  initial bus_rdata = 8'h00;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (done) ndone <= ndone + 1;
    if (timeout) nto <= nto + 1;
    if (err) nerr <= nerr + 1;
    bus_ack <= (bus_wr || bus_rd) && !bus_ack;
    if (bus_wr && !bus_ack) begin
      wl_addr[wcnt[7:0]] <= bus_addr;
      wl_data[wcnt[7:0]] <= bus_wdata;
      wcnt <= wcnt + 1;
    end
    if (bus_rd && !bus_ack) begin
      bus_rdata <= rd_match(rcnt - rbase, cfg_nbad, cfg_alt) ? cfg_exp : ~cfg_exp;
      if (bus_addr != cfg_addr) rd_badaddr <= rd_badaddr + 1;
      rcnt <= rcnt + 1;
    end
  end

  always @(posedge clk) if (cyc == 100000) begin
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] exp_wr(logic er, logic [4:0] b, logic [15:0] a, logic [7:0] d, int j);
    int s = j / 2;
    logic [7:0] bv;
    if (j % 2 == 0) begin
      case (s)
        0, 2: bv = 8'h01;
        1, 4: bv = 8'h00;
        3: bv = er ? 8'h01 : {3'b000, b};
        default: bv = {3'b000, b};
      endcase
      return {16'hC000, bv};
    end
    case (s)
      0, 3: return (s == 3 && !er) ? {a, d} : {16'h9555, 8'hAA};
      1, 4: return {16'hAAAA, 8'h55};
      2: return {16'h9555, er ? 8'h80 : 8'hA0};
      default: return {a, 8'h30};
    endcase
  endfunction

  // fields: op, bank, addr, data, limit, nbad, alt, kind(0 done,1 timeout,2 err)
  localparam int VN = 9;
  localparam logic [44:0] VEC [VN] = '{
    {1'b1, 5'h03, 16'h9000, 8'h00, 8'd10, 4'd2, 1'b0, 2'd0},
    {1'b0, 5'h1F, 16'hBFFF, 8'h5A, 8'd10, 4'd0, 1'b0, 2'd0},
    {1'b0, 5'h00, 16'h8000, 8'h00, 8'd10, 4'd3, 1'b1, 2'd0},
    {1'b1, 5'h10, 16'hB000, 8'h00, 8'd4,  4'd5, 1'b0, 2'd1},
    {1'b1, 5'h02, 16'h8800, 8'h00, 8'd10, 4'd0, 1'b0, 2'd2},
    {1'b1, 5'h02, 16'hC000, 8'h00, 8'd10, 4'd0, 1'b0, 2'd2},
    {1'b0, 5'h02, 16'h7FFF, 8'h11, 8'd10, 4'd0, 1'b0, 2'd2},
    {1'b1, 5'h1F, 16'h8000, 8'h00, 8'd2,  4'd0, 1'b0, 2'd0},
    {1'b0, 5'h05, 16'hA123, 8'hC3, 8'd3,  4'd2, 1'b0, 2'd1}
  };

  task automatic run_vec(logic [44:0] v);
    logic er = v[44];
    logic [4:0] b = v[43:39];
    logic [15:0] a = v[38:23];
    logic [7:0] d = v[22:15];
    int lim = int'(v[14:7]);
    int kind = int'(v[1:0]);
    int wb, d0, t0, e0, nw, exp_reads, n;
    logic ph;
    logic [23:0] got, want;
    int bad;
    cfg_nbad = int'(v[6:3]); cfg_alt = v[2];
    cfg_exp = er ? 8'hFF : d; cfg_addr = a;
    exp_reads = lim;
    ph = 1'b0;
    for (int i = 0; i < lim; i++) begin
      if (rd_match(i, cfg_nbad, cfg_alt) && ph) begin exp_reads = i + 1; break; end
      ph = rd_match(i, cfg_nbad, cfg_alt);
    end
    @(negedge clk);
    wb = wcnt; rbase = rcnt; d0 = ndone; t0 = nto; e0 = nerr;
    op_erase = er; bank_i = b; addr_i = a; data_i = d; poll_limit = 16'(lim); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (kind != 2) chk("R9 busy after start", int'(busy), 1);
    n = 0;
    while (!(done || timeout || err) && n < 2000) begin @(negedge clk); n++; end
    if (kind != 2) chk("R9 busy low with end pulse", int'(busy), 0);
    repeat (4) @(negedge clk);
    chk(kind == 0 ? "R6 done count" : kind == 1 ? "R8 timeout count" : "R5 err count",
        kind == 0 ? ndone - d0 : kind == 1 ? nto - t0 : nerr - e0, 1);
    chk("R9 no other pulse", (ndone - d0) + (nto - t0) + (nerr - e0), 1);
    nw = (kind == 2) ? 0 : (er ? 12 : 8);
    chk(er ? "R3 write count" : "R4 write count", wcnt - wb, nw);
    bad = 0;
    for (int j = 0; j < nw; j++) begin
      got = {wl_addr[(wb + j) % 256], wl_data[(wb + j) % 256]};
      want = exp_wr(er, b, a, d, j);
      if (got != want) begin
        bad++;
        $display("FAIL R2 write %0d: actual=%0h expected=%0h", j, got, want);
      end
    end
    checks++; if (bad != 0) errors++;
    chk(kind == 2 ? "R5 no reads" : kind == 1 ? "R8 read count" : "R7 read count",
        rcnt - rbase, kind == 2 ? 0 : exp_reads);
    chk("R6 read address", rd_badaddr, 0);
    chk("R8 idle after end", int'(busy), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset busy", int'(busy), 0);
    chk("R1 reset strobes", int'(bus_wr) + int'(bus_rd), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 idle outputs", int'(busy) + int'(done) + int'(timeout) + int'(err) + int'(bus_wr) + int'(bus_rd), 0);

    for (int k = 0; k < VN; k++) run_vec(VEC[k]);

    // R10: start during busy is ignored
    begin
      int wb;
      int d0;
      @(negedge clk);
      wb = wcnt; rbase = rcnt; d0 = ndone;
      cfg_nbad = 0; cfg_alt = 1'b0; cfg_exp = 8'h77; cfg_addr = 16'h8123;
      op_erase = 1'b0; bank_i = 5'h02; addr_i = 16'h8123; data_i = 8'h77; poll_limit = 16'd10;
      start = 1'b1;
      @(negedge clk); start = 1'b0;
      repeat (5) @(negedge clk);
      op_erase = 1'b1; bank_i = 5'h09; addr_i = 16'h9000; start = 1'b1;
      @(negedge clk); start = 1'b0;
      repeat (60) @(negedge clk);
      chk("R10 single completion", ndone - d0, 1);
      chk("R10 write count", wcnt - wb, 8);
      chk("R10 final write", int'({wl_addr[(wb + 7) % 256], wl_data[(wb + 7) % 256]}), int'(24'h812377));
      chk("R10 final bank", int'(wl_data[(wb + 6) % 256]), 2);
      chk("R10 idle afterwards", int'(busy), 0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule